// File: doc/BRIEF.md
# Isochronous Cycle Timing Monitor

This block sits beside the link layer of a serial bus with isochronous cycles and watches the bus events that mark each cycle. When cycles overrun, go missing or carry an unexpected time stamp, it raises three single-clock event pulses. These pulses are meant to feed the edge-triggered interrupt sources of an event register. When the local node acts as cycle master and a cycle runs longer than the nominal 125 µs, the block also asks for the cycle-master control bit to be cleared. This ends cycle-master mode without software having to step in.

The monitor reports a missing cycle in two ways. It reports it late, when two local cycle-synch ticks pass without any cycle-start being sent or received. It reports it early, when the gap ordering after a tick shows that no cycle-start can still arrive. It reports at most one missing cycle per synch interval. A received cycle-start is also compared against the local cycle timer: the seconds and count fields must match the timer, unless the node itself is cycle master.

The 125 µs limit is given in system clocks through a parameter, for example 6144 clocks at 49.152 MHz. Packet generation and the cycle timer itself are outside this block.

Top module: `cycle_guard`

## Requirements
- R1: With the master input at 1, a start-sent strobe arms an overrun counter. If no subaction gap follows, the overrun pulse is high in the cycle after the LIMIT-th clock edge that follows the strobe edge.
- R2: A subaction gap strobe on any edge from the first through the LIMIT-th after the start-sent strobe cancels the overrun, so no pulse follows.
- R3: A start-sent strobe with the master input at 0 arms nothing. If the master input falls to 0 while armed, the armed overrun is abandoned and no pulse follows.
- R4: The clear-master request pulse is high in exactly the same cycle as the overrun pulse.
- R5: A local synch tick raises the lost pulse in the next cycle when an earlier tick was seen, no cycle-start (sent or received) arrived since that tick, and no lost event was reported for that interval.
- R6: A cycle-start sent or received between two synch ticks keeps the lost pulse low, even when it follows the first subaction gap of the interval.
- R7: After a synch tick, if a subaction gap occurs while the first gap of the interval is still waiting for a cycle-start, the lost pulse rises one cycle later (early prediction).
- R8: After a synch tick, an arbitration reset gap that arrives before any cycle-start raises the lost pulse one cycle later (early prediction).
- R9: At most one lost pulse is reported per synch interval. An early report suppresses further early reports and the late report at the closing tick.
- R10: On a received cycle-start strobe with the master input at 0, the inconsistent pulse rises one cycle later if the received seconds value differs from timer bits 31:25 or the received count value differs from timer bits 24:12. Timer bits 11:0 are not compared.
- R11: The stamp comparison is skipped while the master input is 1 and in cycles without a received cycle-start strobe.
- R12: All outputs are registered, are low after reset, and an overrun pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_master_i | input | 1 | Cycle-master control bit |
| start_sent_i | input | 1 | Strobe: started sending a cycle-start |
| start_rcvd_i | input | 1 | Strobe: valid cycle-start received |
| sub_gap_i | input | 1 | Strobe: end of a subaction gap |
| arb_gap_i | input | 1 | Strobe: arbitration reset gap seen |
| synch_tick_i | input | 1 | Strobe: local cycle-synch tick |
| rx_sec_i | input | 7 | Seconds field of the received cycle-start |
| rx_cnt_i | input | 13 | Count field of the received cycle-start |
| local_timer_i | input | 32 | Local cycle timer value |
| too_long_o | output | 1 | Cycle overrun event pulse |
| lost_o | output | 1 | Lost cycle event pulse |
| incons_o | output | 1 | Inconsistent cycle-start event pulse |
| clr_master_o | output | 1 | Request to clear the cycle-master bit |

## Verification
The hardest state to reach from the ports is an interval that has already reported an early loss and then meets both more gaps and its closing synch tick. A second report there would break the once-per-interval rule. The stimulus table first plays a clean interval, then a gap-gap pair, a third gap and a closing tick, and then an arbitration-gap interval closed by another tick. Each step of this sequence checks that the lost pulse appears once and only once. The overrun case is checked cycle by cycle around the limit edge, with the bench setting a small limit, including a gap that lands exactly on the LIMIT-th edge.

// File: rtl/cg_pkg.sv
package cg_pkg;
    // Field layout of the local cycle timer that the stamp check relies on
    localparam int TMR_W   = 32;
    localparam int SEC_W   = 7;
    localparam int CNT_W   = 13;
    localparam int SEC_LSB = 25;
    localparam int CNT_LSB = 12;

    typedef struct packed {
        logic synch;
        logic sent;
        logic rcvd;
        logic gap;
        logic arb;
    } bus_evt_t;
endpackage

// File: rtl/cg_overrun.sv
module cg_overrun #(
    parameter int LIMIT = 6144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic start_i,
    input  logic gap_i,
    output logic fire_o,
    output logic clr_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
        logic          fire;
        logic          clr;
    } ovr_t;

    ovr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        st_d.clr  = 1'b0;
        if (!master_i) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (start_i) begin
            st_d.armed = 1'b1;
            st_d.cnt   = CW'(1);
        end else if (st_q.armed) begin
            if (gap_i) begin
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else if (st_q.cnt == CW'(LIMIT)) begin
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
                st_d.fire  = 1'b1;
                st_d.clr   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o = st_q.fire;
    assign clr_o  = st_q.clr;

    // R1: the counter never runs past the limit
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(LIMIT));
    // R3: an overrun only follows a cycle with the master bit set
    a_r3_fire_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |-> $past(master_i));
    // R2: a gap while armed prevents the pulse in the next cycle
    a_r2_gap_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && gap_i && !start_i) |=> !st_q.fire);
endmodule

// File: rtl/cg_lost.sv
module cg_lost
    import cg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_evt_t ev_i,
    output logic     lost_o
);
    typedef struct packed {
        logic seen;   // at least one synch tick observed
        logic got;    // cycle-start seen in the current interval
        logic pend;   // first gap seen, waiting for a cycle-start
        logic rep;    // lost already reported for this interval
        logic lost;
    } lst_t;

    lst_t st_d, st_q;
    lst_t base;
    logic closing;
    logic early;

    always_comb begin
        closing = ev_i.synch && st_q.seen && !st_q.got && !st_q.rep;
        base    = st_q;
        if (ev_i.synch) begin
            base.seen = 1'b1;
            base.got  = 1'b0;
            base.pend = 1'b0;
            base.rep  = 1'b0;
        end
        early = 1'b0;
        st_d  = base;
        if (ev_i.sent || ev_i.rcvd) begin
            st_d.got  = 1'b1;
            st_d.pend = 1'b0;
        end else if (base.seen && !base.got) begin
            if (ev_i.arb) begin
                early = !base.rep;
            end else if (ev_i.gap) begin
                if (base.pend) early = !base.rep;
                else           st_d.pend = 1'b1;
            end
        end
        if (early) st_d.rep = 1'b1;
        st_d.lost = closing || early;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost_o = st_q.lost;

    // R9: once reported, nothing more until the next synch tick
    a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rep && !ev_i.synch) |=> !st_q.lost);
    // R5: a lost pulse always traces back to a tick or a gap
    a_r5_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lost |-> $past(ev_i.synch || ev_i.gap || ev_i.arb));
    // R6: a cycle-start without a tick never produces a loss
    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_i.sent || ev_i.rcvd) && !ev_i.synch) |=> !st_q.lost);
endmodule

// File: rtl/cg_stamp.sv
module cg_stamp
    import cg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rcvd_i,
    input  logic             master_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [TMR_W-1:0] timer_i,
    output logic             mis_o
);
    typedef struct packed {
        logic mis;
    } stp_t;

    stp_t st_d, st_q;
    logic sec_ne, cnt_ne;

    always_comb begin
        sec_ne    = sec_i != timer_i[SEC_LSB +: SEC_W];
        cnt_ne    = cnt_i != timer_i[CNT_LSB +: CNT_W];
        st_d.mis  = rcvd_i && !master_i && (sec_ne || cnt_ne);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mis_o = st_q.mis;

    // R11: comparison only on a received strobe outside master mode
    a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mis |-> $past(rcvd_i && !master_i));
    // R10: matching fields never flag
    a_r10_match_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_i == timer_i[31:25] && cnt_i == timer_i[24:12]) |=> !st_q.mis);
endmodule

// File: rtl/cycle_guard.sv
module cycle_guard
    import cg_pkg::*;
#(
    parameter int LIMIT = 6144
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_master_i,
    input  logic        start_sent_i,
    input  logic        start_rcvd_i,
    input  logic        sub_gap_i,
    input  logic        arb_gap_i,
    input  logic        synch_tick_i,
    input  logic [6:0]  rx_sec_i,
    input  logic [12:0] rx_cnt_i,
    input  logic [31:0] local_timer_i,
    output logic        too_long_o,
    output logic        lost_o,
    output logic        incons_o,
    output logic        clr_master_o
);
    bus_evt_t ev;

    always_comb begin
        ev.synch = synch_tick_i;
        ev.sent  = start_sent_i;
        ev.rcvd  = start_rcvd_i;
        ev.gap   = sub_gap_i;
        ev.arb   = arb_gap_i;
    end

    cg_overrun #(.LIMIT(LIMIT)) u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .master_i (cyc_master_i),
        .start_i  (start_sent_i),
        .gap_i    (sub_gap_i),
        .fire_o   (too_long_o),
        .clr_o    (clr_master_o)
    );

    cg_lost u_lost (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev),
        .lost_o (lost_o)
    );

    cg_stamp u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rcvd_i   (start_rcvd_i),
        .master_i (cyc_master_i),
        .sec_i    (rx_sec_i),
        .cnt_i    (rx_cnt_i),
        .timer_i  (local_timer_i),
        .mis_o    (incons_o)
    );

    // R4: clear request and overrun event coincide
    a_r4_clear_with_event: assert property (@(posedge clk) disable iff (!rst_n)
        too_long_o == clr_master_o);
    // R12: the overrun pulse is one cycle wide
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        too_long_o |=> !too_long_o);
endmodule

// File: tb/sim_cycle_guard.sv
module sim_cycle_guard;
    localparam int LIM = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master = 1'b0, sent = 1'b0, rcvd = 1'b0, gap = 1'b0, arb = 1'b0, synch = 1'b0;
    logic [6:0]  rsec = '0;
    logic [12:0] rcnt = '0;
    logic [31:0] tmr = '0;
    logic        tl, lost, inc, clrm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cycle_guard #(.LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_master_i(master),
        .start_sent_i(sent), .start_rcvd_i(rcvd), .sub_gap_i(gap),
        .arb_gap_i(arb), .synch_tick_i(synch),
        .rx_sec_i(rsec), .rx_cnt_i(rcnt), .local_timer_i(tmr),
        .too_long_o(tl), .lost_o(lost), .incons_o(inc), .clr_master_o(clrm)
    );

    // Row bits: {synch, sent, rcvd, gap, arb, expected lost}
    localparam logic [5:0] VEC [18] = '{
        6'b100000, // first tick, nothing to close
        6'b010000, // start sent (R6)
        6'b000100, // gap after start
        6'b100000, // tick closes a good interval (R6)
        6'b000100, // first gap, waiting
        6'b001000, // start received after gap (R6)
        6'b100000, // good interval
        6'b000000, // idle
        6'b100001, // tick with no start: late loss (R5)
        6'b000100, // first gap
        6'b000101, // second gap before start: early loss (R7)
        6'b000100, // no repeat (R9)
        6'b100000, // closing tick silent after early report (R9)
        6'b000011, // arbitration gap before start: early loss (R8)
        6'b100000, // closing tick silent (R9)
        6'b010000, // start sent
        6'b000010, // arbitration gap after start: quiet
        6'b100000  // good interval
    };

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        sent = 0; rcvd = 0; gap = 0; arb = 0; synch = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_in();
        master = 0;
        rst_n = 0;
        step();
        rst_n = 1;
        step();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        @(negedge clk);
        step();
        chk("R12", tl, 1'b0, "too_long in reset");
        chk("R12", lost, 1'b0, "lost in reset");
        chk("R12", inc, 1'b0, "incons in reset");
        chk("R12", clrm, 1'b0, "clr_master in reset");
        rst_n = 1;
        step();

        // Lost-cycle table: R5 R6 R7 R8 R9
        for (int i = 0; i < 18; i++) begin
            {synch, sent, rcvd, gap, arb} = VEC[i][5:1];
            step();
            chk("R5-table", lost, VEC[i][0], $sformatf("lost row %0d", i));
            chk("R10-table", inc, 1'b0, $sformatf("incons row %0d", i));
        end
        idle_in();

        // R1 R4 R12: overrun fires after LIMIT edges
        do_reset();
        master = 1;
        sent = 1;
        step();
        sent = 0;
        chk("R1", tl, 1'b0, "no pulse at start");
        for (int k = 1; k <= LIM; k++) begin
            step();
            chk("R1", tl, k == LIM, $sformatf("too_long at edge %0d", k));
            chk("R4", clrm, k == LIM, $sformatf("clr_master at edge %0d", k));
        end
        step();
        chk("R12", tl, 1'b0, "pulse one cycle wide");

        // R2: gap on the LIMIT-th edge cancels
        do_reset();
        master = 1;
        sent = 1;
        step();
        sent = 0;
        for (int k = 1; k < LIM; k++) step();
        gap = 1;
        step();
        gap = 0;
        chk("R2", tl, 1'b0, "gap at limit edge");
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R2", tl, 1'b0, "after gap");
        end

        // R3: start with master low arms nothing
        do_reset();
        sent = 1;
        step();
        sent = 0;
        master = 1;
        for (int k = 0; k < LIM + 3; k++) step();
        chk("R3", tl, 1'b0, "start while not master");

        // R3: master drops while armed
        do_reset();
        master = 1;
        sent = 1;
        step();
        sent = 0;
        step();
        step();
        master = 0;
        step();
        master = 1;
        for (int k = 0; k < LIM + 3; k++) begin
            step();
            chk("R3", tl, 1'b0, "after master drop");
        end

        // R10 R11: stamp comparison
        do_reset();
        tmr = {7'd45, 13'd5000, 12'hABC};
        rsec = 7'd45; rcnt = 13'd5000;
        rcvd = 1; step(); rcvd = 0;
        chk("R10", inc, 1'b0, "fields match");
        rsec = 7'd46;
        rcvd = 1; step(); rcvd = 0;
        chk("R10", inc, 1'b1, "seconds differ");
        step();
        chk("R12", inc, 1'b0, "incons back low");
        rsec = 7'd45; rcnt = 13'd4999;
        rcvd = 1; step(); rcvd = 0;
        chk("R10", inc, 1'b1, "count differs");
        rcnt = 13'd5000; tmr[11:0] = 12'h123;
        rcvd = 1; step(); rcvd = 0;
        chk("R10", inc, 1'b0, "low timer bits ignored");
        rsec = 7'd0;
        master = 1;
        rcvd = 1; step(); rcvd = 0;
        chk("R11", inc, 1'b0, "master blocks compare");
        master = 0;
        step();
        chk("R11", inc, 1'b0, "no strobe no compare");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule